// File: doc/BRIEF.md
# EEPROM Write Sequencer with Acknowledge Polling

This block is the master side of a byte write to a two-wire serial EEPROM. A host pulses `start` with a 7-bit device address, an 8-bit word address and a data byte. The sequencer sends the write transaction: a start condition, the control byte, the word address, the data and a stop. The stop launches the memory's internally timed programming cycle.

The sequencer does not wait a fixed worst-case time. It polls the device instead. Each poll is a start condition and the same control byte with the read/write bit at 0, followed by a stop. A device that is still programming leaves SDA high in the acknowledge slot, and the poll is repeated. The first acknowledged poll ends the operation with `done`. If a set number of polls all go unacknowledged, the operation ends with `timeoutErr` instead.

Both bus lines are open drain. The block only asserts pull-low enables, and it reads SDA back through `sdaIn`. SCL comes from a divider: one bit time is four quarter periods of `QTR_CYCLES` clocks each.

Top module: `ackpoll_writer`

## Requirements
- R1: After reset, `busy`, `done` and `timeoutErr` are 0, and both `sclOe` and `sdaOe` are 0 (lines released).
- R2: A `start` pulse while `busy` is 0 sets `busy`. The block then sends a start condition, the control byte `{devAddr,1'b0}`, `wordAddr` and `wrData`, each byte MSB first with a ninth clock for acknowledge, and then a stop.
- R3: The start condition of the first poll has its SDA falling edge no more than 4*QTR_CYCLES+4 clocks after the SDA rising edge of the write's stop.
- R4: Each poll is a start condition followed by exactly one byte, `{devAddr,1'b0}`. No word address or data byte follows it.
- R5: A poll answered with SDA high in the acknowledge slot is closed by a stop before the next start. The bus never sees a repeated start.
- R6: A poll answered with SDA low in the acknowledge slot is closed by a stop. Then `done` becomes 1 and `busy` becomes 0. `done` and `timeoutErr` are never 1 together.
- R7: After MAX_POLLS consecutive unacknowledged polls, the block sends its stop, sets `timeoutErr`, drops `busy` and issues no further start.
- R8: Outside start and stop conditions, SDA changes only while SCL is low. The SCL period within a byte is 4*QTR_CYCLES clocks.
- R9: `done` and `timeoutErr` hold their value until the next accepted `start`. That start clears both in the same edge that sets `busy`.
- R10: A `start` pulse while `busy` is 1 is ignored. The bytes on the bus keep the values captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a write-and-poll operation (accepted when idle) |
| devAddr | input | 7 | 7-bit device address |
| wordAddr | input | 8 | Memory word address |
| wrData | input | 8 | Byte to write |
| sdaIn | input | 1 | Sensed level of the SDA line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation ended with an acknowledged poll |
| timeoutErr | output | 1 | Last operation hit the poll limit |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
The bench sweeps the number of busy polls from zero, where the first poll is acknowledged, through one below the limit, exactly the limit and past it. This targets an off-by-one in the poll counter, which would report a timeout one poll early or allow an extra poll. The counts of start and stop conditions are checked together with a repeated-start detector. A design that skipped the stop after a NACK, or that moved SDA while SCL was high, would therefore show extra or merged bus conditions. Start pulses injected mid-operation with altered arguments catch a design that reloads its address or data while busy. Timing checks on the gap between the stop and the first poll, and on the SCL period, catch a hidden fixed wait or a miscounted divider.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [1:0] {SYM_START, SYM_STOP, SYM_BYTE} symKind_t;

  typedef struct packed {
    logic     go;
    symKind_t kind;
    logic [7:0] byteVal;
  } symCmd_t;
endpackage

// File: rtl/ackpoll_bitpath.sv
module ackpoll_bitpath
  import ackpoll_pkg::*;
#(
  parameter int QTR_CYCLES = 125
) (
  input  logic    clk,
  input  logic    rstN,
  input  symCmd_t cmd,
  input  logic    sdaIn,
  output logic    ready,
  output logic    symDone,
  output logic    ackSeen,
  output logic    sclOe,
  output logic    sdaOe
);
  localparam int DIV_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QTR_CYCLES - 1);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic             active;
  symKind_t         kind;
  logic [7:0]       shiftReg;
  logic [3:0]       bitIdx;
  logic [1:0]       phase;
  logic [DIV_W-1:0] divCnt;
  logic             drvScl, drvSda;

  wire qtrEnd  = active && (divCnt == DIV_LAST);
  wire lastBit = (kind != SYM_BYTE) || (bitIdx == ACK_SLOT);

  assign ready = !active;

  // Pull-low pattern for the current quarter of the current symbol
  always_comb begin
    unique case (kind)
      SYM_START: begin drvScl = (phase == 2'd3); drvSda = phase[1];  end
      SYM_STOP:  begin drvScl = (phase == 2'd0); drvSda = !phase[1]; end
      default: begin
        drvScl = (phase == 2'd0) || (phase == 2'd3);
        drvSda = (bitIdx == ACK_SLOT) ? 1'b0 : !shiftReg[7];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      kind     <= SYM_STOP;
      shiftReg <= '0;
      bitIdx   <= '0;
      phase    <= '0;
      divCnt   <= '0;
      symDone  <= 1'b0;
      ackSeen  <= 1'b0;
      sclOe    <= 1'b0;
      sdaOe    <= 1'b0;
    end else begin
      symDone <= 1'b0;
      if (!active) begin
        if (cmd.go) begin
          active   <= 1'b1;
          kind     <= cmd.kind;
          shiftReg <= cmd.byteVal;
          bitIdx   <= '0;
          phase    <= '0;
          divCnt   <= '0;
        end
      end else begin
        sclOe <= drvScl;
        sdaOe <= drvSda;
        if (qtrEnd) begin
          divCnt <= '0;
          if (phase == 2'd2 && kind == SYM_BYTE && bitIdx == ACK_SLOT)
            ackSeen <= !sdaIn;
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (lastBit) begin
              active  <= 1'b0;
              symDone <= 1'b1;
            end else begin
              bitIdx   <= bitIdx + 4'd1;
              shiftReg <= {shiftReg[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // SDA may move while SCL is high only inside a start or stop symbol
  assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaOe != $past(sdaOe)) && !sclOe && !$past(sclOe)) |-> (kind != SYM_BYTE));

  // The sequencer never issues a symbol while one is in flight
  assert_cmd_when_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> ready);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    symDone |=> !symDone);
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int MAX_POLLS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [6:0] devAddr,
  input  logic [7:0] wordAddr,
  input  logic [7:0] wrData,
  input  logic       ready,
  input  logic       symDone,
  input  logic       ackSeen,
  output symCmd_t    cmd,
  output logic       busy,
  output logic       done,
  output logic       timeoutErr
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] POLL_LIMIT = CNT_W'(MAX_POLLS);

  typedef enum logic [3:0] {
    ST_IDLE, ST_W_START, ST_W_DEV, ST_W_WORD, ST_W_DATA, ST_W_STOP,
    ST_P_START, ST_P_DEV, ST_P_STOP
  } seqState_t;

  seqState_t        state;
  logic             pending;
  logic             gotAck;
  logic [6:0]       devReg;
  logic [7:0]       wordReg, dataReg;
  logic [CNT_W-1:0] pollCnt;

  always_comb begin
    cmd.go      = (state != ST_IDLE) && !pending && ready;
    cmd.kind    = SYM_BYTE;
    cmd.byteVal = {devReg, 1'b0};
    unique case (state)
      ST_W_START, ST_P_START: cmd.kind = SYM_START;
      ST_W_STOP,  ST_P_STOP:  cmd.kind = SYM_STOP;
      ST_W_WORD:              cmd.byteVal = wordReg;
      ST_W_DATA:              cmd.byteVal = dataReg;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pending    <= 1'b0;
      gotAck     <= 1'b0;
      devReg     <= '0;
      wordReg    <= '0;
      dataReg    <= '0;
      pollCnt    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (cmd.go) pending <= 1'b1;
      if (state == ST_IDLE) begin
        if (start) begin
          devReg     <= devAddr;
          wordReg    <= wordAddr;
          dataReg    <= wrData;
          pollCnt    <= '0;
          busy       <= 1'b1;
          done       <= 1'b0;
          timeoutErr <= 1'b0;
          state      <= ST_W_START;
        end
      end else if (symDone) begin
        pending <= 1'b0;
        unique case (state)
          ST_W_START: state <= ST_W_DEV;
          ST_W_DEV:   state <= ST_W_WORD;
          ST_W_WORD:  state <= ST_W_DATA;
          ST_W_DATA:  state <= ST_W_STOP;
          ST_W_STOP:  state <= ST_P_START;
          ST_P_START: state <= ST_P_DEV;
          ST_P_DEV: begin
            gotAck <= ackSeen;
            if (!ackSeen) pollCnt <= pollCnt + CNT_W'(1);
            state <= ST_P_STOP;
          end
          ST_P_STOP: begin
            if (gotAck) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else if (pollCnt == POLL_LIMIT) begin
              timeoutErr <= 1'b1;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end else begin
              state <= ST_P_START;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeoutErr));

  assert_poll_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_LIMIT);

  assert_flags_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!done && !timeoutErr));

  assert_hold_args_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(devReg) && $stable(wordReg) && $stable(dataReg)));
endmodule

// File: rtl/ackpoll_writer.sv
module ackpoll_writer
  import ackpoll_pkg::*;
#(
  parameter int QTR_CYCLES = 125,
  parameter int MAX_POLLS  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [6:0] devAddr,
  input  logic [7:0] wordAddr,
  input  logic [7:0] wrData,
  input  logic       sdaIn,
  output logic       busy,
  output logic       done,
  output logic       timeoutErr,
  output logic       sclOe,
  output logic       sdaOe
);
  symCmd_t cmd;
  logic    ready, symDone, ackSeen;

  ackpoll_seq #(.MAX_POLLS(MAX_POLLS)) seqInst (
    .clk(clk), .rstN(rstN), .start(start), .devAddr(devAddr),
    .wordAddr(wordAddr), .wrData(wrData), .ready(ready),
    .symDone(symDone), .ackSeen(ackSeen), .cmd(cmd),
    .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  ackpoll_bitpath #(.QTR_CYCLES(QTR_CYCLES)) pathInst (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaIn(sdaIn), .ready(ready),
    .symDone(symDone), .ackSeen(ackSeen), .sclOe(sclOe), .sdaOe(sdaOe)
  );
endmodule

// File: tb/ackpoll_writer_test.sv
`timescale 1ns/1ps
module ackpoll_writer_test;
  localparam int QTR = 2;
  localparam int MAXP = 5;
  localparam int SCL_PERIOD_NS = 4 * QTR * 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [6:0] devAddr = '0;
  logic [7:0] wordAddr = '0, wrData = '0;
  logic busy, done, timeoutErr, sclOe, sdaOe;
  logic slvLow = 1'b0;
  logic sclBus, sdaBus;

  assign sclBus = !sclOe;
  assign sdaBus = !(sdaOe || slvLow);

  always #10 clk = !clk;

  ackpoll_writer #(.QTR_CYCLES(QTR), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .devAddr(devAddr),
    .wordAddr(wordAddr), .wrData(wrData), .sdaIn(sdaBus), .busy(busy),
    .done(done), .timeoutErr(timeoutErr), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Device model on the bus
  int nStarts, nStops, rptStarts, bitCnt, byteInTxn, pollsSeen, busyN;
  int badCtrl, extraBytes, gapFirst;
  bit inTxn;
  logic [7:0] sh, expCtrl, rxWord, rxData;
  time tLastStop, tRise1, tRise2;

  task automatic clearModel();
    nStarts = 0; nStops = 0; rptStarts = 0; bitCnt = 0; byteInTxn = 0;
    pollsSeen = 0; badCtrl = 0; extraBytes = 0; gapFirst = -1; inTxn = 0;
    rxWord = 8'hxx; rxData = 8'hxx; tRise1 = 0; tRise2 = 0; slvLow = 1'b0;
  endtask

  always @(negedge sdaBus) if (sclBus === 1'b1) begin
    if (inTxn) rptStarts++;
    if (nStarts == 1 && nStops == 1) gapFirst = int'(($time - tLastStop) / 20);
    nStarts++; inTxn = 1; bitCnt = 0; byteInTxn = 0;
  end

  always @(posedge sdaBus) if (sclBus === 1'b1) begin
    nStops++; inTxn = 0; tLastStop = $time;
  end

  always @(posedge sclBus) if (inTxn) begin
    if (bitCnt < 8) sh = {sh[6:0], sdaBus};
    if (nStarts == 1 && byteInTxn == 0 && bitCnt == 0) tRise1 = $time;
    if (nStarts == 1 && byteInTxn == 0 && bitCnt == 1) tRise2 = $time;
    bitCnt++;
  end

  always @(negedge sclBus) if (inTxn) begin
    if (bitCnt == 8) begin
      if (byteInTxn == 0) begin
        if (sh !== expCtrl) badCtrl++;
        if (nStarts == 1) slvLow = 1'b1;
        else begin
          slvLow = (pollsSeen >= busyN);
          pollsSeen++;
        end
      end else begin
        if (nStarts == 1 && byteInTxn == 1) rxWord = sh;
        else if (nStarts == 1 && byteInTxn == 2) rxData = sh;
        else extraBytes++;
        slvLow = 1'b1;
      end
    end else if (bitCnt == 9) begin
      slvLow = 1'b0; bitCnt = 0; byteInTxn++;
    end
  end

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) check(0, req, "watchdog expired, busy stuck", 1, 0);
  endtask

  task automatic runOp(input logic [6:0] d, input logic [7:0] w,
                       input logic [7:0] v, input int nBusy, input bit intrude);
    int polls, expStarts;
    bit expTo;
    clearModel();
    busyN = nBusy; expCtrl = {d, 1'b0};
    @(negedge clk); devAddr = d; wordAddr = w; wrData = v; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1 && done === 1'b0 && timeoutErr === 1'b0, "R9",
          "accept clears flags and sets busy", int'(busy), 1);
    if (intrude) begin
      repeat (30) @(negedge clk);
      devAddr = ~d; wordAddr = ~w; wrData = ~v; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (300) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    waitIdle("R6");
    repeat (4) @(negedge clk);
    expTo = (nBusy >= MAXP);
    polls = expTo ? MAXP : nBusy + 1;
    expStarts = 1 + polls;
    check(done === !expTo, "R6", "done", int'(done), int'(!expTo));
    check(timeoutErr === expTo, "R7", "timeoutErr", int'(timeoutErr), int'(expTo));
    check(busy === 1'b0, "R6", "busy after end", int'(busy), 0);
    check(nStarts == expStarts, "R5", "start conditions", nStarts, expStarts);
    check(nStops == expStarts, "R5", "stop conditions", nStops, expStarts);
    check(rptStarts == 0, "R5", "repeated starts", rptStarts, 0);
    check(pollsSeen == polls, "R7", "polls issued", pollsSeen, polls);
    check(badCtrl == 0, "R4", "bad control bytes", badCtrl, 0);
    check(extraBytes == 0, "R4", "bytes after poll control", extraBytes, 0);
    check(rxWord === w, "R2", "word address", int'(rxWord), int'(w));
    check(rxData === v, "R2", "data byte", int'(rxData), int'(v));
    check(gapFirst >= 0 && gapFirst <= 4 * QTR + 4, "R3", "stop-to-poll gap",
          gapFirst, 4 * QTR + 4);
    check(tRise2 - tRise1 == SCL_PERIOD_NS, "R8", "SCL period ns",
          int'(tRise2 - tRise1), SCL_PERIOD_NS);
    if (intrude)
      check(busy === 1'b0, "R10", "intruding start left no new run", int'(busy), 0);
  endtask

  initial begin
    clearModel();
    busyN = 0; expCtrl = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(done === 1'b0 && timeoutErr === 1'b0, "R1", "flags after reset",
          int'(done) + int'(timeoutErr), 0);
    check(sclOe === 1'b0 && sdaOe === 1'b0, "R1", "lines released",
          int'(sclOe) + int'(sdaOe), 0);

    for (int n = 0; n <= MAXP + 2; n++) begin
      logic [6:0] d = 7'h50 ^ 7'(n * 13);
      logic [7:0] w = 8'hA5 ^ 8'(n * 37);
      runOp(d, w, ~w + 8'(n), n, 1'b0);
    end

    // Flags persist while idle
    repeat (50) @(negedge clk);
    check(timeoutErr === 1'b1 && done === 1'b0, "R9", "flag held while idle",
          int'(timeoutErr), 1);

    runOp(7'h2C, 8'h00, 8'hFF, 2, 1'b1);
    runOp(7'h7F, 8'hFF, 8'h00, MAXP, 1'b1);
    runOp(7'h00, 8'h80, 8'h01, MAXP - 1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule